// File: doc/BRIEF.md
# Clause-locking wavefront issue arbiter

This block chooses which wavefronts may issue instructions in a compute unit that several wavefronts share. In every cycle each wavefront offers at most one instruction. The offer is made up of a valid flag, a 4-bit instruction class code and a clause marker. The decoder sets the clause marker on the instruction that directly follows a clause-start instruction. For each instruction class the arbiter grants at most one wavefront per cycle. It normally chooses that wavefront by round-robin.

A marked instruction of a lockable class can be granted. When it is, its wavefront becomes the owner of that class, and the arbiter then grants that class only to the owner. The owner loses the lock when it offers an instruction of another class. For scalar memory the lock also ends once a set number of scalar-memory grants has gone to the owner within the clause. Classes that are not locked keep ordinary round-robin arbitration. For each class the block reports, from registers, whether a clause is active and which wavefront owns it.

Top module: `wv_clause_arb`

## Requirements
- R1: After a synchronous reset no class is locked, every owner field reads 0 and every round-robin pointer starts at wavefront 0, so wavefront 0 wins the first contest in any class.
- R2: Within one class at most one wavefront is granted per cycle. The grant goes to the first requesting wavefront found by searching upward (wrapping) from the slot after the most recently granted wavefront of that class. Grant bit t*NUM_WAVES+w of issue_grant means that wavefront w is granted class t.
- R3: Different classes are arbitrated independently, and each can grant in the same cycle. The class codes are 0 vector ALU, 1 scalar memory, 2 LDS, 3 flat, 4 texture, 5 buffer, 6 global, 7 scratch, 8 scalar ALU and 9 branch/other.
- R4: When a marked instruction of a lockable class (codes 0 to 7) is granted, clause_active[t] is high and the owner field t (clause_owner[t*2+:2] by default) holds that wavefront from the next cycle. A marked instruction that loses round-robin opens nothing.
- R5: A marked instruction of class 8 or 9 is granted like any other instruction and never sets clause_active.
- R6: While class t is locked, no wavefront other than the owner is granted class t.
- R7: The lock on class t clears on the cycle after the owner offers a valid instruction of a different class. A cycle in which the owner offers nothing leaves the lock and the owner unchanged.
- R8: A scalar-memory clause ends on the cycle after its SMEM_LIMIT-th scalar-memory grant, counting the marked opener (default 8). A limit of 0 removes the cap.
- R9: A marked instruction from a second wavefront in a class that is already locked is held back. It opens its own clause when it is granted after the release.
- R10: When a lock ends, the round-robin pointer of that class moves to the wavefront after the former owner.
- R11: While one class is locked, the other classes keep granting by round-robin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wave_valid | input | NUM_WAVES | Wavefront w offers an instruction this cycle |
| wave_type | input | NUM_WAVES*4 | Class code of each offered instruction, 4 bits per wavefront |
| wave_mark | input | NUM_WAVES | Offered instruction is the first one after a clause-start |
| issue_grant | output | 10*NUM_WAVES | One-hot grant per class, bit t*NUM_WAVES+w |
| clause_active | output | 10 | Class t is locked (registered) |
| clause_owner | output | 10*log2(NUM_WAVES) | Owning wavefront per class (registered) |

## Verification
The properties assume that each wavefront presents one fixed class code on any cycle in which it is valid. They also assume that a wavefront keeps offering a held instruction until that instruction is granted, and that it raises the marker only together with a valid instruction. The stimulus keeps to these assumptions: every cycle is built from explicit valid, class and marker vectors, and the marker is never raised on an idle slot. In the clause sequences the owner goes idle, changes class and reaches the scalar-memory cap while competing wavefronts keep requesting the locked class.

// File: rtl/wv_clause_pkg.sv
package wv_clause_pkg;
   localparam int NUM_TYPES = 10;
   localparam int TYPE_W    = 4;

   typedef enum logic [TYPE_W-1:0] {
      IT_VALU    = 4'd0,
      IT_SMEM    = 4'd1,
      IT_LDS     = 4'd2,
      IT_FLAT    = 4'd3,
      IT_TEX     = 4'd4,
      IT_BUF     = 4'd5,
      IT_GLOBAL  = 4'd6,
      IT_SCRATCH = 4'd7,
      IT_SALU    = 4'd8,
      IT_OTHER   = 4'd9
   } itype_e;

   // classes 0..7 may be locked by a clause
   function automatic bit can_lock(int t);
      return (t >= 0) && (t <= int'(IT_SCRATCH));
   endfunction
endpackage

// File: rtl/wcl_rr_arb.sv
module wcl_rr_arb #(
   parameter int NW  = 4,
   parameter int WID = (NW > 1) ? $clog2(NW) : 1
) (
   input  logic           clk,
   input  logic           rst,
   input  logic [NW-1:0]  req,
   input  logic           rel,
   input  logic [WID-1:0] rel_from,
   output logic [NW-1:0]  gnt
);
   logic [WID-1:0] ptr;
   logic [WID-1:0] gidx;

   function automatic logic [WID-1:0] nxt(input logic [WID-1:0] x);
      return (int'(x) == NW - 1) ? '0 : x + 1'b1;
   endfunction

   always_comb begin
      logic found;
      found = 1'b0;
      gnt   = '0;
      for (int i = 0; i < NW; i++) begin
         int idx;
         idx = (int'(ptr) + i) % NW;
         if (!found && req[idx]) begin
            gnt[idx] = 1'b1;
            found    = 1'b1;
         end
      end
   end

   always_comb begin
      gidx = '0;
      for (int w = 0; w < NW; w++)
         if (gnt[w]) gidx = WID'(w);
   end

   always_ff @(posedge clk) begin
      if (rst)         ptr <= '0;
      else if (rel)    ptr <= nxt(rel_from);
      else if (|gnt)   ptr <= nxt(gidx);
   end

   AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst) $onehot0(gnt)); // R2
   AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (rst) (gnt & ~req) == '0); // R2
endmodule

// File: rtl/wcl_clause_lock.sv
module wcl_clause_lock #(
   parameter int NW       = 4,
   parameter int WID      = (NW > 1) ? $clog2(NW) : 1,
   parameter int LIMIT    = 0,
   parameter bit LOCKABLE = 1'b1
) (
   input  logic           clk,
   input  logic           rst,
   input  logic [NW-1:0]  req,
   input  logic [NW-1:0]  other,
   input  logic [NW-1:0]  mark,
   input  logic [NW-1:0]  gnt,
   output logic [NW-1:0]  elig,
   output logic           active,
   output logic [WID-1:0] owner,
   output logic           rel
);
   localparam bit HAS_LIMIT = (LIMIT > 0);
   localparam int CW        = $clog2(LIMIT + 2);

   logic [NW-1:0]  owner_oh;
   logic [WID-1:0] gidx;
   logic           opening;
   logic           type_exit;
   logic           limit_hit;

   assign owner_oh  = NW'(1) << owner;
   assign elig      = active ? (req & owner_oh) : req;
   assign opening   = LOCKABLE && !active && (|(gnt & mark));
   assign type_exit = active && other[owner];
   assign rel       = type_exit || limit_hit;

   always_comb begin
      gidx = '0;
      for (int w = 0; w < NW; w++)
         if (gnt[w]) gidx = WID'(w);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         active <= 1'b0;
         owner  <= '0;
      end else if (opening) begin
         active <= 1'b1;
         owner  <= gidx;
      end else if (rel) begin
         active <= 1'b0;
      end
   end

   generate
      if (HAS_LIMIT) begin : g_cap
         logic [CW-1:0] cnt;
         assign limit_hit = active && gnt[owner] && (cnt == CW'(LIMIT - 1));
         always_ff @(posedge clk) begin
            if (rst)                        cnt <= '0;
            else if (opening)               cnt <= CW'(1);
            else if (active && gnt[owner])  cnt <= cnt + 1'b1;
         end
         AST_SMEM_CAP: assert property (@(posedge clk) disable iff (rst) active |-> (int'(cnt) < LIMIT)); // R8
      end else begin : g_nocap
         assign limit_hit = 1'b0;
      end

      if (!LOCKABLE) begin : g_nolock
         AST_NEVER_LOCKS: assert property (@(posedge clk) disable iff (rst) !active); // R5
      end
   endgenerate

   AST_LOCK_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) active |-> (gnt & ~owner_oh) == '0); // R6
   AST_TYPE_EXIT: assert property (@(posedge clk) disable iff (rst) (active && other[owner]) |=> !active); // R7
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      (active && !req[owner] && !other[owner]) |=> (active && $stable(owner))); // R7
   AST_OPEN_NEXT: assert property (@(posedge clk) disable iff (rst)
      (LOCKABLE && !active && |(gnt & mark)) |=> (active && owner == $past(gidx))); // R4
endmodule

// File: rtl/wv_clause_arb.sv
module wv_clause_arb
   import wv_clause_pkg::*;
#(
   parameter int NUM_WAVES  = 4,
   parameter int SMEM_LIMIT = 8,
   localparam int WID = (NUM_WAVES > 1) ? $clog2(NUM_WAVES) : 1,
   localparam int NT  = NUM_TYPES,
   localparam int TW  = TYPE_W
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic [NUM_WAVES-1:0]    wave_valid,
   input  logic [NUM_WAVES*TW-1:0] wave_type,
   input  logic [NUM_WAVES-1:0]    wave_mark,
   output logic [NT*NUM_WAVES-1:0] issue_grant,
   output logic [NT-1:0]           clause_active,
   output logic [NT*WID-1:0]       clause_owner
);
   generate
      if (NUM_WAVES < 2) begin : g_bad_waves
         $error("NUM_WAVES must be at least 2");
      end
      if (SMEM_LIMIT == 1 || SMEM_LIMIT < 0) begin : g_bad_limit
         $error("SMEM_LIMIT must be 0 or at least 2");
      end

      for (genvar t = 0; t < NT; t++) begin : g_type
         logic [NUM_WAVES-1:0] req, other, elig, gnt;
         logic                 rel, act;
         logic [WID-1:0]       own;

         always_comb begin
            for (int w = 0; w < NUM_WAVES; w++) begin
               req[w]   = wave_valid[w] && (wave_type[w*TW +: TW] == TW'(t));
               other[w] = wave_valid[w] && (wave_type[w*TW +: TW] != TW'(t));
            end
         end

         wcl_clause_lock #(
            .NW       (NUM_WAVES),
            .WID      (WID),
            .LIMIT    ((t == int'(IT_SMEM)) ? SMEM_LIMIT : 0),
            .LOCKABLE (can_lock(t))
         ) u_lock (
            .clk    (clk),
            .rst    (rst),
            .req    (req),
            .other  (other),
            .mark   (wave_mark),
            .gnt    (gnt),
            .elig   (elig),
            .active (act),
            .owner  (own),
            .rel    (rel)
         );

         wcl_rr_arb #(
            .NW  (NUM_WAVES),
            .WID (WID)
         ) u_rr (
            .clk      (clk),
            .rst      (rst),
            .req      (elig),
            .rel      (rel),
            .rel_from (own),
            .gnt      (gnt)
         );

         assign issue_grant[t*NUM_WAVES +: NUM_WAVES] = gnt;
         assign clause_active[t]                      = act;
         assign clause_owner[t*WID +: WID]            = own;
      end
   endgenerate
endmodule

// File: tb/wv_clause_arb_tb.sv
module wv_clause_arb_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NW = 4;
   localparam int NT = 10;

   typedef struct {
      string        tag;
      logic [39:0]  g;
      logic [9:0]   a;
      logic [19:0]  o;
   } item_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [3:0]  wave_valid = '0;
   logic [15:0] wave_type  = '0;
   logic [3:0]  wave_mark  = '0;
   logic [39:0] issue_grant;
   logic [9:0]  clause_active;
   logic [19:0] clause_owner;

   int    n_checks = 0;
   int    n_fails  = 0;
   bit    done     = 1'b0;
   item_t q[$];

   wv_clause_arb #(.NUM_WAVES(NW), .SMEM_LIMIT(8)) u_dut (
      .clk           (clk),
      .rst           (rst),
      .wave_valid    (wave_valid),
      .wave_type     (wave_type),
      .wave_mark     (wave_mark),
      .issue_grant   (issue_grant),
      .clause_active (clause_active),
      .clause_owner  (clause_owner)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [39:0] gb(int t, int w);
      return 40'(1) << (t*NW + w);
   endfunction

   // driver: apply one cycle of offers and queue what must be seen
   task automatic step(input logic [3:0] v, input logic [3:0] t0, t1, t2, t3,
                       input logic [3:0] m, input logic [39:0] eg,
                       input logic [9:0] ea, input logic [19:0] eo, input string tag);
      item_t it;
      @(negedge clk);
      wave_valid = v;
      wave_type  = {t3, t2, t1, t0};
      wave_mark  = m;
      it.tag = tag; it.g = eg; it.a = ea; it.o = eo;
      q.push_back(it);
   endtask

   // monitor: compare a quarter period after the inputs settle
   initial begin
      forever begin
         @(negedge clk);
         #(CLK_PERIOD/4);
         if (q.size() > 0) begin
            item_t it;
            bit    bad;
            it  = q.pop_front();
            bad = 1'b0;
            n_checks++;
            if (issue_grant !== it.g) begin
               bad = 1'b1;
               $display("FAIL %s grant: got %h expected %h", it.tag, issue_grant, it.g);
            end
            if (clause_active !== it.a) begin
               bad = 1'b1;
               $display("FAIL %s active: got %b expected %b", it.tag, clause_active, it.a);
            end
            for (int t = 0; t < NT; t++) begin
               if (it.a[t] && clause_owner[t*2 +: 2] !== it.o[t*2 +: 2]) begin
                  bad = 1'b1;
                  $display("FAIL %s owner[%0d]: got %0d expected %0d", it.tag, t,
                           clause_owner[t*2 +: 2], it.o[t*2 +: 2]);
               end
            end
            if (bad) n_fails++;
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      // R1 reset state
      step(4'b0000, 0,0,0,0, 4'b0000, '0, '0, '0, "R1 idle after reset");
      step(4'b1111, 0,0,0,0, 4'b0000, gb(0,0), '0, '0, "R1 R2 first contest to w0");
      step(4'b1111, 0,0,0,0, 4'b0000, gb(0,1), '0, '0, "R2 rotate to w1");
      step(4'b0011, 0,0,0,0, 4'b0000, gb(0,0), '0, '0, "R2 wrap to w0");
      // R3 parallel classes: w0 VALU, w1 SMEM, w2 LDS, w3 SALU
      step(4'b1111, 0,1,2,8, 4'b0000, gb(0,0)|gb(1,1)|gb(2,2)|gb(8,3), '0, '0, "R3 parallel classes");
      // R4 marked w2 loses round-robin first
      step(4'b1111, 0,0,0,0, 4'b0100, gb(0,1), '0, '0, "R4 marked loser opens nothing");
      step(4'b1111, 0,0,0,0, 4'b0100, gb(0,2), '0, '0, "R4 marked winner");
      step(4'b1111, 0,0,0,0, 4'b0000, gb(0,2), 10'b1, 20'd2, "R4 R6 clause owner w2");
      // owner idle: no VALU grant, other classes round-robin
      step(4'b1011, 0,1,0,2, 4'b0000, gb(1,1)|gb(2,3), 10'b1, 20'd2, "R7 R11 owner idle holds lock");
      // owner switches to SALU: exit
      step(4'b1111, 0,0,8,0, 4'b0000, gb(8,2), 10'b1, 20'd2, "R6 R7 exit cycle still exclusive");
      step(4'b1011, 0,0,0,0, 4'b0000, gb(0,3), '0, '0, "R7 R10 released, pointer after owner");
      // R5 marked SALU opens nothing
      step(4'b0010, 0,8,0,0, 4'b0010, gb(8,1), '0, '0, "R5 marked SALU granted");
      step(4'b0000, 0,0,0,0, 4'b0000, '0, '0, '0, "R5 no clause from SALU");
      // R8 scalar-memory clause by w3, w1 waiting with its own marker
      step(4'b1000, 0,0,0,1, 4'b1000, gb(1,3), '0, '0, "R8 SMEM clause opener");
      for (int k = 0; k < 7; k++)
         step(4'b1010, 0,1,0,1, 4'b0010, gb(1,3), 10'b10, 20'hC, "R8 R9 SMEM clause holds");
      step(4'b1010, 0,1,0,1, 4'b0010, gb(1,1), '0, '0, "R8 R9 R10 cap reached, waiting wave opens");
      step(4'b1010, 0,1,0,1, 4'b0000, gb(1,1), 10'b10, 20'h4, "R9 second clause owner w1");
      step(4'b1010, 0,0,0,1, 4'b0000, gb(0,1), 10'b10, 20'h4, "R6 R11 owner leaves SMEM");
      step(4'b0000, 0,0,0,0, 4'b0000, '0, '0, '0, "R7 SMEM clause ended");
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule